// File: doc/BRIEF.md
# Trigger Class Matrix with Detector Cluster Fan-out

This block makes one level of trigger decision for a readout system that serves many detectors. On every cycle where `eval` is high it samples a vector of trigger input bits, the busy flags of the detectors and the results of a small set of shared past/future protection circuits. It then decides, in parallel, which of its programmable trigger classes fire. A class fires when all of the inputs in its mask are present and all of the protection results it selects are satisfied. It is blocked when any cluster in its busy selection is busy, and it must also be assigned to a cluster.

Detectors are grouped into a small number of clusters, and the grouping can be changed at run time. A cluster counts as busy when any detector assigned to it is busy. A cluster triggers when any class assigned to it fires. Each detector channel then receives the trigger of the cluster it belongs to. All three result vectors (class, cluster, detector) are registered, so they appear one clock after the sampling cycle.

The configuration is loaded through a single-cycle write port. The address carries a field code and an index. Writes are committed only in cycles where `eval` is low, so the configuration cannot change under an evaluation.

Top module: `trig_class_matrix`

## Requirements
- R1: After reset all outputs are zero and every configuration field is zero, so no class fires and no detector belongs to a cluster.
- R2: In the clock after a cycle with `eval` high, `class_trig[c]` is 1 exactly when class c has a nonzero input mask covered by `trig_in`, every protection bit it selects is 1 in `pf_ok`, no cluster in its busy selection is busy, and its cluster id is valid.
- R3: A class whose input mask is zero never fires, even with every input, protection and busy condition favourable.
- R4: A class is blocked when any protection result it selects is 0. Unselected protection bits have no effect.
- R5: A cluster is busy when any detector whose cluster id names it has its `det_busy` bit set. Busy flags of detectors outside the selected clusters, or of unassigned detectors, do not block the class.
- R6: `clu_trig[k]` is the OR of the fired classes whose cluster id is k+1.
- R7: `det_trig[d]` equals the `clu_trig` bit of the cluster named by detector d's id, and is 0 for an unassigned detector.
- R8: In the clock after a cycle with `eval` low, all three output vectors are zero.
- R9: A write presented while `eval` is high is discarded. A write presented while `eval` is low is in effect at the next evaluation.
- R10: Cluster id 0 and ids above the cluster count mean "unassigned": such a class never fires and such a detector never receives a trigger.
- R11: `cfg_addr` is {field[2:0], index[5:0]}. Field 0 is the class input mask, 1 the class protection select, 2 the class busy-cluster select, 3 the class cluster id and 4 the detector cluster id. Field codes 5 to 7 and indices at or beyond the class or detector count change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval | input | 1 | Evaluate the sampled inputs in this cycle |
| trig_in | input | 24 | Trigger input bits |
| pf_ok | input | 4 | Shared protection results, 1 = satisfied |
| det_busy | input | 24 | Per-detector busy flags |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 9 | {field, index} |
| cfg_wdata | input | 24 | Write data, right aligned |
| class_trig | output | 50 | Registered class decisions |
| clu_trig | output | 6 | Registered cluster triggers |
| det_trig | output | 24 | Registered per-detector triggers |

## Verification
The bench builds the block with its default sizes: 24 inputs, 50 classes, 24 detectors, 6 clusters and 4 protection circuits. At these sizes the 6-bit index can address the unused class slots 50 to 63 and detector slots 24 to 63. The 3-bit cluster id can encode the invalid value 7, and the field codes 5 to 7 exist but are unused. All of these out-of-range encodings are driven on purpose. Sparse random masks over dense random inputs make classes fire often enough that the cluster OR and the detector fan-out are exercised while busy vetoes and protection vetoes land on them.

// File: rtl/trig_cls_pkg.sv
package trig_cls_pkg;

   localparam int FIELD_W = 3;

   typedef enum logic [FIELD_W-1:0] {
      FLD_MASK      = 3'd0,
      FLD_PFSEL     = 3'd1,
      FLD_BUSYSEL   = 3'd2,
      FLD_CLASS_CLU = 3'd3,
      FLD_DET_CLU   = 3'd4
   } cfg_field_e;

   function automatic int unsigned max2(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/trig_cfg_store.sv
module trig_cfg_store
   import trig_cls_pkg::*;
#(
   parameter int N_IN   = 24,
   parameter int N_CLS  = 50,
   parameter int N_DET  = 24,
   parameter int N_CLU  = 6,
   parameter int N_PF   = 4,
   parameter int CFG_DW = 24,
   parameter int IDXW   = 6,
   parameter int CIDW   = 3,
   parameter int ADDR_W = IDXW + FIELD_W
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            hold,
   input  logic                            we,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [CFG_DW-1:0]               wdata,
   output logic [N_CLS-1:0][N_IN-1:0]      cls_mask,
   output logic [N_CLS-1:0][N_PF-1:0]      cls_pfsel,
   output logic [N_CLS-1:0][N_CLU-1:0]     cls_bsel,
   output logic [N_CLS-1:0][CIDW-1:0]      cls_cid,
   output logic [N_DET-1:0][CIDW-1:0]      det_cid
);

   logic [FIELD_W-1:0] fld;
   logic [IDXW-1:0]    idx;
   logic               commit;

   assign fld    = addr[ADDR_W-1 -: FIELD_W];
   assign idx    = addr[IDXW-1:0];
   // writes that arrive during an evaluation are dropped
   assign commit = we & ~hold;

   for (genvar c = 0; c < N_CLS; c++) begin : g_cls
      logic hit;
      assign hit = commit && (idx == IDXW'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cls_mask[c]  <= '0;
            cls_pfsel[c] <= '0;
            cls_bsel[c]  <= '0;
            cls_cid[c]   <= '0;
         end else if (hit) begin
            if (fld == FLD_MASK)      cls_mask[c]  <= wdata[N_IN-1:0];
            if (fld == FLD_PFSEL)     cls_pfsel[c] <= wdata[N_PF-1:0];
            if (fld == FLD_BUSYSEL)   cls_bsel[c]  <= wdata[N_CLU-1:0];
            if (fld == FLD_CLASS_CLU) cls_cid[c]   <= wdata[CIDW-1:0];
         end
      end
   end

   for (genvar d = 0; d < N_DET; d++) begin : g_det
      logic hit;
      assign hit = commit && (idx == IDXW'(d)) && (fld == FLD_DET_CLU);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   det_cid[d] <= '0;
         else if (hit) det_cid[d] <= wdata[CIDW-1:0];
      end
   end

endmodule

// File: rtl/trig_class_eval.sv
module trig_class_eval #(
   parameter int N_IN  = 24,
   parameter int N_CLS = 50,
   parameter int N_CLU = 6,
   parameter int N_PF  = 4,
   parameter int CIDW  = 3
) (
   input  logic [N_IN-1:0]                 trig_in,
   input  logic [N_PF-1:0]                 pf_ok,
   input  logic [N_CLU-1:0]                clu_busy,
   input  logic [N_CLS-1:0][N_IN-1:0]      cls_mask,
   input  logic [N_CLS-1:0][N_PF-1:0]      cls_pfsel,
   input  logic [N_CLS-1:0][N_CLU-1:0]     cls_bsel,
   input  logic [N_CLS-1:0][CIDW-1:0]      cls_cid,
   output logic [N_CLS-1:0]                fire
);

   localparam logic [CIDW-1:0] CID_MAX = CIDW'(N_CLU);

   for (genvar c = 0; c < N_CLS; c++) begin : g_cls
      logic mask_live, inputs_met, pf_met, vetoed, cid_valid;

      assign mask_live  = |cls_mask[c];
      assign inputs_met = &(trig_in | ~cls_mask[c]);
      assign pf_met     = &(pf_ok | ~cls_pfsel[c]);
      assign vetoed     = |(clu_busy & cls_bsel[c]);
      assign cid_valid  = (cls_cid[c] != '0) && (cls_cid[c] <= CID_MAX);
      assign fire[c]    = mask_live & inputs_met & pf_met & ~vetoed & cid_valid;
   end

endmodule

// File: rtl/trig_cluster_route.sv
module trig_cluster_route #(
   parameter int N_CLS = 50,
   parameter int N_DET = 24,
   parameter int N_CLU = 6,
   parameter int CIDW  = 3
) (
   input  logic [N_DET-1:0]                det_busy,
   input  logic [N_DET-1:0][CIDW-1:0]      det_cid,
   input  logic [N_CLS-1:0]                fire,
   input  logic [N_CLS-1:0][CIDW-1:0]      cls_cid,
   output logic [N_CLU-1:0]                clu_busy,
   output logic [N_CLU-1:0]                clu_fire,
   output logic [N_DET-1:0]                det_fire
);

   // cluster k is addressed by id k+1; id 0 and ids past N_CLU match nothing
   for (genvar k = 0; k < N_CLU; k++) begin : g_clu
      localparam logic [CIDW-1:0] MY_ID = CIDW'(k + 1);
      logic [N_DET-1:0] member;
      logic [N_CLS-1:0] owned;

      for (genvar d = 0; d < N_DET; d++) begin : g_mem
         assign member[d] = (det_cid[d] == MY_ID);
      end
      for (genvar c = 0; c < N_CLS; c++) begin : g_own
         assign owned[c] = (cls_cid[c] == MY_ID);
      end

      assign clu_busy[k] = |(member & det_busy);
      assign clu_fire[k] = |(owned & fire);
   end

   for (genvar d = 0; d < N_DET; d++) begin : g_fan
      always_comb begin
         det_fire[d] = 1'b0;
         for (int k = 0; k < N_CLU; k++) begin
            if (det_cid[d] == CIDW'(k + 1)) det_fire[d] = clu_fire[k];
         end
      end
   end

endmodule

// File: rtl/trig_class_matrix.sv
module trig_class_matrix
   import trig_cls_pkg::*;
#(
   parameter int N_IN   = 24,
   parameter int N_CLS  = 50,
   parameter int N_DET  = 24,
   parameter int N_CLU  = 6,
   parameter int N_PF   = 4,
   parameter int CFG_DW = 24,
   localparam int IDXW   = $clog2(max2(N_CLS, N_DET)),
   localparam int CIDW   = $clog2(N_CLU + 1),
   localparam int ADDR_W = IDXW + FIELD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eval,
   input  logic [N_IN-1:0]   trig_in,
   input  logic [N_PF-1:0]   pf_ok,
   input  logic [N_DET-1:0]  det_busy,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_wdata,
   output logic [N_CLS-1:0]  class_trig,
   output logic [N_CLU-1:0]  clu_trig,
   output logic [N_DET-1:0]  det_trig
);

   if (CFG_DW < N_IN || CFG_DW < N_PF || CFG_DW < N_CLU || CFG_DW < CIDW) begin : g_bad_dw
      $error("trig_class_matrix: CFG_DW narrower than a configuration field");
   end
   if (N_CLU < 1 || N_CLS < 1 || N_DET < 1 || N_IN < 1 || N_PF < 1) begin : g_bad_cnt
      $error("trig_class_matrix: every count must be at least one");
   end

   logic [N_CLS-1:0][N_IN-1:0]  cls_mask;
   logic [N_CLS-1:0][N_PF-1:0]  cls_pfsel;
   logic [N_CLS-1:0][N_CLU-1:0] cls_bsel;
   logic [N_CLS-1:0][CIDW-1:0]  cls_cid;
   logic [N_DET-1:0][CIDW-1:0]  det_cid;

   logic [N_CLU-1:0] clu_busy;
   logic [N_CLS-1:0] fire;
   logic [N_CLU-1:0] clu_fire;
   logic [N_DET-1:0] det_fire;

   trig_cfg_store #(
      .N_IN(N_IN), .N_CLS(N_CLS), .N_DET(N_DET), .N_CLU(N_CLU), .N_PF(N_PF),
      .CFG_DW(CFG_DW), .IDXW(IDXW), .CIDW(CIDW), .ADDR_W(ADDR_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .hold(eval), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .cls_mask(cls_mask), .cls_pfsel(cls_pfsel),
      .cls_bsel(cls_bsel), .cls_cid(cls_cid), .det_cid(det_cid)
   );

   trig_class_eval #(
      .N_IN(N_IN), .N_CLS(N_CLS), .N_CLU(N_CLU), .N_PF(N_PF), .CIDW(CIDW)
   ) u_eval (
      .trig_in(trig_in), .pf_ok(pf_ok), .clu_busy(clu_busy),
      .cls_mask(cls_mask), .cls_pfsel(cls_pfsel), .cls_bsel(cls_bsel),
      .cls_cid(cls_cid), .fire(fire)
   );

   trig_cluster_route #(
      .N_CLS(N_CLS), .N_DET(N_DET), .N_CLU(N_CLU), .CIDW(CIDW)
   ) u_route (
      .det_busy(det_busy), .det_cid(det_cid), .fire(fire), .cls_cid(cls_cid),
      .clu_busy(clu_busy), .clu_fire(clu_fire), .det_fire(det_fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         class_trig <= '0;
         clu_trig   <= '0;
         det_trig   <= '0;
      end else if (eval) begin
         class_trig <= fire;
         clu_trig   <= clu_fire;
         det_trig   <= det_fire;
      end else begin
         class_trig <= '0;
         clu_trig   <= '0;
         det_trig   <= '0;
      end
   end

endmodule

// File: rtl/trig_class_matrix_chk.sv
module trig_class_matrix_chk #(
   parameter int N_IN  = 24,
   parameter int N_CLS = 50,
   parameter int N_DET = 24,
   parameter int N_CLU = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             eval,
   input logic [N_IN-1:0]  trig_in,
   input logic [N_CLS-1:0] class_trig,
   input logic [N_CLU-1:0] clu_trig,
   input logic [N_DET-1:0] det_trig
);

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eval |=> (class_trig == '0 && clu_trig == '0 && det_trig == '0));

   // R3
   no_input_no_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && trig_in == '0) |=> (class_trig == '0));

   // R6
   cluster_needs_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clu_trig != '0) |-> (class_trig != '0));

   // R7
   detector_needs_cluster_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (det_trig != '0) |-> (clu_trig != '0));

endmodule

bind trig_class_matrix trig_class_matrix_chk #(
   .N_IN(N_IN), .N_CLS(N_CLS), .N_DET(N_DET), .N_CLU(N_CLU)
) u_chk (
   .clk(clk), .rst_n(rst_n), .eval(eval), .trig_in(trig_in),
   .class_trig(class_trig), .clu_trig(clu_trig), .det_trig(det_trig)
);

// File: tb/trig_class_matrix_test.sv
module trig_class_matrix_test;

   localparam int CLK_P = 10;
   localparam int NI = 24, NC = 50, ND = 24, NK = 6, NP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          eval = 1'b0;
   logic [NI-1:0] trig_in = '0;
   logic [NP-1:0] pf_ok = '0;
   logic [ND-1:0] det_busy = '0;
   logic          cfg_we = 1'b0;
   logic [8:0]    cfg_addr = '0;
   logic [23:0]   cfg_wdata = '0;
   logic [NC-1:0] class_trig;
   logic [NK-1:0] clu_trig;
   logic [ND-1:0] det_trig;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [NI-1:0] m_mask [NC];
   logic [NP-1:0] m_pf   [NC];
   logic [NK-1:0] m_bsel [NC];
   logic [2:0]    m_ccid [NC];
   logic [2:0]    m_dcid [ND];

   logic [NC-1:0] e_cls;
   logic [NK-1:0] e_clu;
   logic [ND-1:0] e_det;

   always #(CLK_P/2) clk = ~clk;

   trig_class_matrix uut (
      .clk(clk), .rst_n(rst_n), .eval(eval), .trig_in(trig_in), .pf_ok(pf_ok),
      .det_busy(det_busy), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .class_trig(class_trig), .clu_trig(clu_trig),
      .det_trig(det_trig)
   );

   function automatic bit cid_ok(logic [2:0] id);
      return (id != 3'd0) && (id <= 3'(NK));
   endfunction

   task automatic model(input logic [NI-1:0] in, input logic [NP-1:0] pf,
                        input logic [ND-1:0] busy);
      logic [NK-1:0] cb;
      cb = '0;
      for (int d = 0; d < ND; d++)
         if (cid_ok(m_dcid[d]) && busy[d]) cb[m_dcid[d]-1] = 1'b1;
      e_cls = '0; e_clu = '0; e_det = '0;
      for (int c = 0; c < NC; c++) begin
         if (m_mask[c] != '0 && (in & m_mask[c]) == m_mask[c] &&
             (pf & m_pf[c]) == m_pf[c] && (cb & m_bsel[c]) == '0 && cid_ok(m_ccid[c])) begin
            e_cls[c] = 1'b1;
            e_clu[m_ccid[c]-1] = 1'b1;
         end
      end
      for (int d = 0; d < ND; d++)
         if (cid_ok(m_dcid[d])) e_det[d] = e_clu[m_dcid[d]-1];
   endtask

   task automatic check_out(input string tag);
      checks++;
      if (class_trig !== e_cls) begin
         fails++;
         $display("FAIL %s class_trig actual=%h expected=%h", tag, class_trig, e_cls);
      end
      checks++;
      if (clu_trig !== e_clu) begin
         fails++;
         $display("FAIL %s clu_trig actual=%h expected=%h", tag, clu_trig, e_clu);
      end
      checks++;
      if (det_trig !== e_det) begin
         fails++;
         $display("FAIL %s det_trig actual=%h expected=%h", tag, det_trig, e_det);
      end
   endtask

   // apply to the model only what the field/index decoding allows
   task automatic model_write(input logic [2:0] f, input int idx, input logic [23:0] v);
      if (f == 3'd4) begin
         if (idx < ND) m_dcid[idx] = v[2:0];
      end else if (idx < NC) begin
         case (f)
            3'd0: m_mask[idx] = v[NI-1:0];
            3'd1: m_pf[idx]   = v[NP-1:0];
            3'd2: m_bsel[idx] = v[NK-1:0];
            3'd3: m_ccid[idx] = v[2:0];
            default: ;
         endcase
      end
   endtask

   task automatic cfg_write(input logic [2:0] f, input int idx, input logic [23:0] v);
      @(negedge clk);
      eval = 1'b0; cfg_we = 1'b1; cfg_addr = {f, 6'(idx)}; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      model_write(f, idx, v);
   endtask

   task automatic do_eval(input logic [NI-1:0] in, input logic [NP-1:0] pf,
                          input logic [ND-1:0] busy, input string tag);
      @(negedge clk);
      eval = 1'b1; trig_in = in; pf_ok = pf; det_busy = busy;
      model(in, pf, busy);
      @(negedge clk);
      eval = 1'b0;
      check_out(tag);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [23:0] v;
      void'($urandom(32'd4242));
      for (int c = 0; c < NC; c++) begin
         m_mask[c] = '0; m_pf[c] = '0; m_bsel[c] = '0; m_ccid[c] = '0;
      end
      for (int d = 0; d < ND; d++) m_dcid[d] = '0;

      repeat (3) @(negedge clk);
      e_cls = '0; e_clu = '0; e_det = '0;
      check_out("R1 reset outputs");
      rst_n = 1'b1;
      // R1: cleared configuration gives nothing even with everything favourable
      do_eval('1, '1, '0, "R1 cleared config");

      // directed setup: class 0 -> cluster 1, detectors 0..3 in cluster 1
      cfg_write(3'd0, 0, 24'h000028);
      cfg_write(3'd1, 0, 24'h000002);
      cfg_write(3'd3, 0, 24'd1);
      for (int d = 0; d < 4; d++) cfg_write(3'd4, d, 24'd1);
      do_eval(24'h000028, 4'h2, '0, "R2 mask covered fires");
      do_eval(24'h000008, 4'hF, '0, "R2 missing input");
      do_eval(24'hFFFFFF, 4'hD, '0, "R4 selected protection low");
      do_eval(24'hFFFFFF, 4'h2, '0, "R4 unselected protection ignored");

      // R8: the cycle after an idle cycle is quiet
      @(negedge clk);
      e_cls = '0; e_clu = '0; e_det = '0;
      check_out("R8 idle cycle");

      // R3 empty mask with valid cluster; R10 class without cluster
      cfg_write(3'd3, 1, 24'd2);
      cfg_write(3'd0, 2, 24'h000001);
      cfg_write(3'd0, 3, 24'h000001);
      cfg_write(3'd3, 3, 24'd7);
      do_eval('1, '1, '0, "R3 R10 empty mask and invalid id");

      // R5 busy veto through cluster membership
      cfg_write(3'd2, 0, 24'h000001);
      do_eval('1, '1, 24'h000004, "R5 member busy vetoes");
      do_eval('1, '1, 24'h000400, "R5 unassigned busy ignored");
      cfg_write(3'd4, 10, 24'd1);
      do_eval('1, '1, 24'h000400, "R5 newly assigned busy vetoes");

      // R7 repartition: detector 5 joins cluster 1, detector 6 gets invalid id
      cfg_write(3'd4, 5, 24'd1);
      cfg_write(3'd4, 6, 24'd7);
      do_eval('1, '1, '0, "R7 repartition fan-out");

      // R6 two classes into one cluster, one into another
      cfg_write(3'd0, 4, 24'h800000);
      cfg_write(3'd3, 4, 24'd1);
      cfg_write(3'd0, 5, 24'h400000);
      cfg_write(3'd3, 5, 24'd6);
      cfg_write(3'd4, 20, 24'd6);
      do_eval(24'hC00000, '1, '0, "R6 cluster OR");

      // R11 out-of-range index and unused field codes change nothing
      cfg_write(3'd0, 55, 24'h000001);
      cfg_write(3'd4, 30, 24'd1);
      cfg_write(3'd5, 0, 24'h000000);
      cfg_write(3'd7, 4, 24'h000000);
      do_eval('1, '1, '0, "R11 ignored writes");

      // R9 write while eval high is dropped; its own evaluation uses old config
      @(negedge clk);
      eval = 1'b1; trig_in = '1; pf_ok = '1; det_busy = '0;
      cfg_we = 1'b1; cfg_addr = {3'd0, 6'd4}; cfg_wdata = 24'h000000;
      model('1, '1, '0);
      @(negedge clk);
      eval = 1'b0; cfg_we = 1'b0;
      check_out("R9 write during eval");
      do_eval('1, '1, '0, "R9 dropped write left config");
      cfg_write(3'd0, 4, 24'h000000);
      do_eval('1, '1, '0, "R9 idle write takes effect");

      // random phase
      for (int round = 0; round < 4; round++) begin
         for (int c = 0; c < NC; c++) begin
            v = (24'd1 << ($urandom % NI)) | (24'd1 << ($urandom % NI));
            if (($urandom % 10) == 0) v = '0;
            cfg_write(3'd0, c, v);
            cfg_write(3'd1, c, 24'((1 << ($urandom % NP)) & $urandom));
            cfg_write(3'd2, c, 24'((1 << ($urandom % NK)) & $urandom));
            cfg_write(3'd3, c, 24'($urandom % 8));
         end
         for (int d = 0; d < ND; d++) cfg_write(3'd4, d, 24'($urandom % 8));
         for (int i = 0; i < 100; i++) begin
            do_eval(24'($urandom | $urandom | $urandom), 4'($urandom | $urandom),
                    24'($urandom & $urandom & $urandom & $urandom), "R2 random");
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule